// File: doc/BRIEF.md
# Truncating Float-to-Integer Converter

This block turns an already unpacked floating-point operand into a signed two's-complement integer, 32 bits by default. The operand arrives as five fields: a class code, a sign bit, a signed unbiased exponent and a mantissa whose leading one is explicit. The conversion always truncates toward zero, and it ignores any rounding mode programmed elsewhere. Fraction bits that the conversion discards never change the integer. They only raise the inexact flag.

When the value is too large for the result, the output saturates according to the sign and the invalid flag is raised in place of inexact. The overflow test is asymmetric: the most negative integer is accepted, but a positive value of the same magnitude is not. Infinities and both kinds of NaN take this same saturating path.

Operands enter through a valid/ready handshake. Results leave through a second valid/ready handshake with one register stage. The upstream side is stalled only while a finished result is still waiting to be taken.

Top module: `fcvt_trunc_int`

## Requirements
- R1: A zero-class operand (class code 0) gives result 0 with invalid and inexact both clear, whatever the sign, exponent and mantissa.
- R2: A normal operand (class code 1) converts by truncation toward zero. The result magnitude is floor(mantissa × 2^(exponent − 23)), with the leading one at mantissa bit 23. Inexact is set exactly when a nonzero bit was discarded.
- R3: A normal operand with an unbiased exponent of 32 or more overflows, whatever its mantissa.
- R4: A normal operand with a negative exponent gives 0, with inexact set if the mantissa is nonzero and invalid clear.
- R5: After truncation, the magnitude overflows if it is above 0x80000000, or if it equals 0x80000000 and the sign is positive. A negative operand of magnitude 0x80000000 gives 0x80000000 with no invalid flag.
- R6: On overflow, invalid is set, inexact is cleared, and the result is 0x7FFFFFFF for a positive sign or 0x80000000 for a negative sign.
- R7: Infinity (code 2), quiet NaN (code 3), signalling NaN (code 4) and the unused codes 5–7 all take the overflow path of R6.
- R8: A negative operand that does not overflow gives the two's-complement negation of its truncated magnitude.
- R9: in_ready equals (not out_valid) or out_ready. A request accepted at a clock edge is presented with out_valid at the next edge. While out_valid is high and out_ready is low, the result and both flags hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | An operand is offered |
| in_ready | output | 1 | The block can take the operand this cycle |
| in_class | input | 3 | Class code: 0 zero, 1 normal, 2 infinity, 3 quiet NaN, 4 signalling NaN |
| in_sign | input | 1 | Operand sign, 1 for negative |
| in_exp | input | 12 | Signed unbiased exponent |
| in_mant | input | 24 | Mantissa, leading one at bit 23 |
| out_valid | output | 1 | A result is presented |
| out_ready | input | 1 | The consumer takes the result this cycle |
| out_result | output | 32 | Two's-complement integer result |
| out_invalid | output | 1 | Overflow or non-numeric operand |
| out_inexact | output | 1 | Nonzero fraction bits were discarded |

## Verification
Each result is due at the clock edge after its operand is accepted, and it then stays on the outputs until the consumer takes it. The bench records the expected value when an operand is accepted. It compares a result only in a cycle where out_valid and out_ready are both high, sampling between edges. This keeps the comparison correct while the consumer applies irregular back-pressure, and one phase of the test deliberately holds results under a stall.

// File: rtl/fcvt_pkg.sv
package fcvt_pkg;
  typedef enum logic [2:0] {
    CLS_ZERO = 3'd0,
    CLS_NORM = 3'd1,
    CLS_INF  = 3'd2,
    CLS_QNAN = 3'd3,
    CLS_SNAN = 3'd4
  } fp_class_e;
endpackage

// File: rtl/fcvt_align.sv
// Places the mantissa on the integer grid, splitting integer part and discarded bits.
module fcvt_align #(
  parameter int INT_W  = 32,
  parameter int MANT_W = 24,
  parameter int EXP_W  = 12
) (
  input  logic signed [EXP_W-1:0]  exp_i,
  input  logic        [MANT_W-1:0] mant_i,
  output logic        [INT_W-1:0]  mag_o,
  output logic                     big_o,
  output logic                     inexact_o
);
  localparam int FB   = MANT_W - 1;
  localparam int W    = INT_W + MANT_W;
  localparam int SH_W = $clog2(INT_W);
  localparam logic signed [EXP_W-1:0] EXP_LIM = EXP_W'(INT_W);

  logic [W-1:0] wide;

  always_comb begin
    big_o     = (exp_i >= EXP_LIM);
    wide      = '0;
    mag_o     = '0;
    inexact_o = 1'b0;
    if (exp_i < 0) begin
      inexact_o = |mant_i;
    end else if (!big_o) begin
      wide      = W'(mant_i) << exp_i[SH_W-1:0];
      mag_o     = wide[FB +: INT_W];
      inexact_o = |wide[FB-1:0];
    end
  end

  // R4: negative exponents never leave an integer part
  always_comb begin
    if (exp_i < 0) a_r4_neg_exp_zero: assert (mag_o == '0);
  end
endmodule

// File: rtl/fcvt_range.sv
// Range check, sign-dependent saturation and negation.
module fcvt_range
  import fcvt_pkg::*;
#(
  parameter int INT_W = 32
) (
  input  fp_class_e        cls_i,
  input  logic             sign_i,
  input  logic [INT_W-1:0] mag_i,
  input  logic             big_i,
  input  logic             inexact_i,
  output logic [INT_W-1:0] result_o,
  output logic             invalid_o,
  output logic             inexact_o
);
  localparam logic [INT_W-1:0] MIN_MAG = {1'b1, {(INT_W-1){1'b0}}};

  logic ovf;

  always_comb begin
    ovf = 1'b0;
    if (cls_i == CLS_NORM)
      ovf = big_i || (mag_i > MIN_MAG) || ((mag_i == MIN_MAG) && !sign_i);
    else if (cls_i != CLS_ZERO)
      ovf = 1'b1;

    result_o  = '0;
    invalid_o = 1'b0;
    inexact_o = 1'b0;
    if (cls_i == CLS_ZERO) begin
      result_o = '0;
    end else if (ovf) begin
      result_o  = sign_i ? MIN_MAG : ~MIN_MAG;
      invalid_o = 1'b1;
    end else begin
      result_o  = sign_i ? (~mag_i + 1'b1) : mag_i;
      inexact_o = inexact_i;
    end
  end

  // R8: an in-range negative nonzero result has its top bit set
  always_comb begin
    if (cls_i == CLS_NORM && !ovf && sign_i && mag_i != '0)
      a_r8_neg_sign_bit: assert (result_o[INT_W-1]);
  end
endmodule

// File: rtl/fcvt_trunc_int.sv
module fcvt_trunc_int
  import fcvt_pkg::*;
#(
  parameter int INT_W  = 32,
  parameter int MANT_W = 24,
  parameter int EXP_W  = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [2:0]               in_class,
  input  logic                     in_sign,
  input  logic signed [EXP_W-1:0]  in_exp,
  input  logic [MANT_W-1:0]        in_mant,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [INT_W-1:0]         out_result,
  output logic                     out_invalid,
  output logic                     out_inexact
);
  logic [INT_W-1:0] mag;
  logic             big, raw_inexact;
  logic [INT_W-1:0] nxt_result;
  logic             nxt_invalid, nxt_inexact;
  logic             accept;
  fp_class_e        cls;

  assign cls = fp_class_e'(in_class);

  fcvt_align #(.INT_W(INT_W), .MANT_W(MANT_W), .EXP_W(EXP_W)) align_i (
    .exp_i(in_exp), .mant_i(in_mant),
    .mag_o(mag), .big_o(big), .inexact_o(raw_inexact)
  );

  fcvt_range #(.INT_W(INT_W)) range_i (
    .cls_i(cls), .sign_i(in_sign), .mag_i(mag), .big_i(big),
    .inexact_i(raw_inexact),
    .result_o(nxt_result), .invalid_o(nxt_invalid), .inexact_o(nxt_inexact)
  );

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_result  <= '0;
      out_invalid <= 1'b0;
      out_inexact <= 1'b0;
    end else begin
      if (accept) begin
        out_valid   <= 1'b1;
        out_result  <= nxt_result;
        out_invalid <= nxt_invalid;
        out_inexact <= nxt_inexact;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  a_r9_valid_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);

  a_r9_hold_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result)
                                   && $stable(out_invalid) && $stable(out_inexact)));

  a_r1_zero_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_class == 3'd0) |=> (out_result == '0 && !out_invalid && !out_inexact));

  a_r7_nonnum_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_class >= 3'd2) |=> (out_invalid && !out_inexact));

  a_r6_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_invalid && out_inexact));
endmodule

// File: tb/fcvt_trunc_int_tb_top.sv
module fcvt_trunc_int_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [2:0] in_class = '0;
  logic in_sign = 1'b0;
  logic signed [11:0] in_exp = '0;
  logic [23:0] in_mant = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [31:0] out_result;
  logic out_invalid, out_inexact;

  typedef struct {
    logic [31:0] res;
    logic        inv;
    logic        inx;
    string       tag;
  } item_t;

  item_t sb_q[$];
  int n_vec = 0;
  int n_bad = 0;
  bit stall_mode = 1'b0;
  logic [4:0] lfsr = 5'h13;

  always #(CLK_PERIOD/2) clk = ~clk;

  fcvt_trunc_int dut_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_class(in_class), .in_sign(in_sign), .in_exp(in_exp), .in_mant(in_mant),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result), .out_invalid(out_invalid), .out_inexact(out_inexact)
  );

  function automatic item_t model(int cls, bit s, int e, int unsigned m, string tag);
    item_t it;
    longint unsigned mag;
    bit inx = 1'b0;
    bit sat = 1'b0;
    it.tag = tag; it.res = '0; it.inv = 1'b0; it.inx = 1'b0;
    if (cls == 0) return it;
    mag = 0;
    if (cls != 1 || e >= 32) sat = 1'b1;
    else if (e < 0) begin mag = 0; inx = (m != 0); end
    else if (e >= 23) mag = longint'(m) << (e - 23);
    else begin
      mag = longint'(m) >> (23 - e);
      inx = ((m & ((32'd1 << (23 - e)) - 1)) != 0);
    end
    if (!sat && (mag > 64'h8000_0000 || (mag == 64'h8000_0000 && !s))) sat = 1'b1;
    if (sat) begin
      it.res = s ? 32'h8000_0000 : 32'h7FFF_FFFF;
      it.inv = 1'b1;
    end else begin
      it.res = s ? 32'(-mag) : 32'(mag);
      it.inx = inx;
    end
    return it;
  endfunction

  task automatic drive(int cls, bit s, int e, int unsigned m, string tag);
    @(negedge clk);
    in_class = 3'(cls); in_sign = s; in_exp = 12'(e); in_mant = 24'(m);
    in_valid = 1'b1;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    sb_q.push_back(model(cls, s, e, m, tag));
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  // back-pressure
  always @(negedge clk) begin
    lfsr <= {lfsr[3:0], lfsr[4] ^ lfsr[2]};
    out_ready <= stall_mode ? (lfsr[0] & lfsr[3]) : 1'b1;
  end

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (rst_n && out_valid && out_ready) begin
        item_t exp_it;
        n_vec++;
        if (sb_q.size() == 0) begin
          n_bad++;
          $display("FAIL R9 unexpected result %h (expected none)", out_result);
        end else begin
          exp_it = sb_q.pop_front();
          if (out_result !== exp_it.res || out_invalid !== exp_it.inv || out_inexact !== exp_it.inx) begin
            n_bad++;
            $display("FAIL %s: got %h inv=%b inx=%b, expected %h inv=%b inx=%b",
                     exp_it.tag, out_result, out_invalid, out_inexact,
                     exp_it.res, exp_it.inv, exp_it.inx);
          end
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not complete (expected completion)");
    finish_run();
  end

  initial begin
    logic [15:0] r;
    repeat (3) @(posedge clk);
    #1;
    n_vec++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      n_bad++;
      $display("FAIL R9 reset: out_valid=%b in_ready=%b, expected 0 1", out_valid, in_ready);
    end
    rst_n = 1'b1;

    drive(0, 1, 5, 24'hABCDEF, "R1 zero class");
    drive(0, 0, 40, 24'h800000, "R1 zero class big exp");
    drive(1, 0, 0, 24'hC00000, "R2 1.5 truncates to 1");
    drive(1, 0, 23, 24'h800001, "R2 exact at exp 23");
    drive(1, 0, 30, 24'hFFFFFF, "R2 large exact");
    drive(1, 0, 5, 24'hFFFFFF, "R2 discarded bits");
    drive(1, 0, 32, 24'h800000, "R3 exp 32 positive");
    drive(1, 1, 100, 24'h800000, "R3 exp 100 negative");
    drive(1, 0, -1, 24'h800000, "R4 half");
    drive(1, 1, -200, 24'hFFFFFF, "R4 very negative exp");
    drive(1, 1, 31, 24'h800000, "R5 most negative accepted");
    drive(1, 0, 31, 24'h800000, "R5 positive 2^31 overflows");
    drive(1, 1, 31, 24'h800001, "R6 negative beyond range");
    drive(1, 0, 31, 24'hFFFFFF, "R6 positive saturates");
    drive(2, 0, 0, 24'h800000, "R7 +inf");
    drive(2, 1, 0, 24'h800000, "R7 -inf");
    drive(3, 0, 0, 24'hC00000, "R7 quiet NaN");
    drive(4, 1, 0, 24'hA00000, "R7 signalling NaN");
    drive(6, 0, 3, 24'h800000, "R7 unused class code");
    drive(1, 1, 2, 24'hA00000, "R8 minus five");
    drive(1, 1, 1, 24'hE00000, "R8 minus 3.5 truncates");

    stall_mode = 1'b1;
    r = 16'hACE1;
    for (int i = 0; i < 300; i++) begin
      int e;
      r = {r[14:0], r[15] ^ r[13] ^ r[12] ^ r[10]};
      e = int'(r[5:0]) - 8;
      drive((r[9:8] == 2'b11) ? int'(r[11:10]) + 2 : 1, r[7], e,
            {1'b1, r[15:0], r[14:8]}, "R9 stream under back-pressure");
    end
    stall_mode = 1'b0;

    while (sb_q.size() != 0) @(posedge clk);
    repeat (4) @(posedge clk);
    finish_run();
  end
endmodule